// File: doc/BRIEF.md
# AGC Sync Holdoff Scheduler

This block decides when an automatic gain control loop takes a new update and whether that update also reloads the loop's starting parameters. A pin sync or a software sync starts a holdoff down-counter, loaded from a programmable holdoff value. When the count expires, the block emits a one-cycle sync strobe. If initialisation is enabled, an init strobe comes with it. A holdoff of one gives the shortest delay. A holdoff of zero blocks the sync completely.

A 4-bit control field shapes the scheduling. It holds a self-clearing command that syncs at once, an enable that attaches init to every sync, a mode that honours only the first external sync after reset or after a control write, and a bypass level for the downstream data path. The control field is taken on a one-cycle write strobe. The decimator, the loop arithmetic and the output formatting sit outside this block.

Top module: `agc_sync_sched`

## Requirements
- R1: After reset, sync_pulse, init_pulse and bypass are low and no countdown is running.
- R2: Take an external sync (pin_sync or soft_sync) sampled at rising edge k while holdoff = H with H ≥ 1. sync_pulse is then high for exactly one cycle, following edge k+H-1.
- R3: An external sync sampled while holdoff = 0 produces no sync pulse. It also cancels any countdown in progress.
- R4: An external sync that arrives while a countdown is running reloads the counter from holdoff and restarts the countdown. The earlier countdown produces no pulse.
- R5: Writing ctl_data bit 3 = 1 gives one sync_pulse after the edge that follows the write edge. The bit then clears itself, so no further pulse follows.
- R6: With ctl_data bit 2 = 1, init_pulse is high in every cycle in which sync_pulse is high. With the bit at 0, init_pulse stays low.
- R7: With ctl_data bit 1 = 1, only the first external sync after reset or after a control write is honoured. Later external syncs have no effect.
- R8: A control write clears the record of the first sync, so the next external sync is honoured again.
- R9: bypass equals ctl_data bit 0 from the last control write, visible after that write's edge.
- R10: pin_sync and soft_sync high in the same cycle act as a single sync event and give a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | One-cycle write strobe for the control field |
| ctl_data | input | 4 | Control: bit3 sync now, bit2 init on sync, bit1 first sync only, bit0 bypass |
| holdoff | input | CNT_W | Holdoff count loaded on each honoured external sync |
| pin_sync | input | 1 | External sync from a device pin, one-cycle pulse |
| soft_sync | input | 1 | External sync from software, one-cycle pulse |
| sync_pulse | output | 1 | One-cycle sync strobe to the AGC |
| init_pulse | output | 1 | One-cycle initialise strobe, coincident with sync_pulse |
| bypass | output | 1 | Level that routes data around the AGC |

## Verification
The bench builds the block with CNT_W = 4. This puts the full-scale holdoff of 15 within a short window, so the largest delay, the zero-holdoff block and the one-cycle minimum can all be measured against the H-1 latency rule. A vector table covers every mix of sync source, holdoff and init enable. Directed cases cover a retrigger and a cancellation in the middle of a countdown, the first-sync-only mode before and after a control write, and the self-clearing immediate command.

// File: rtl/agc_sync_sched.sv
module agc_sync_sched #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [3:0]       ctl_data,
  input  logic [CNT_W-1:0] holdoff,
  input  logic             pin_sync,
  input  logic             soft_sync,
  output logic             sync_pulse,
  output logic             init_pulse,
  output logic             bypass
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [3:0]       ctrl_q;
  logic             seen_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sync_q, init_q;
  logic             ext, accept, fire;

  assign ext    = pin_sync | soft_sync;
  assign accept = ext && !(ctrl_q[1] && seen_q);
  assign fire   = (accept && holdoff == ONE) || (!accept && cnt_q == ONE) || ctrl_q[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      seen_q <= 1'b0;
      cnt_q  <= '0;
      sync_q <= 1'b0;
      init_q <= 1'b0;
    end else begin
      if (ctl_wr)         ctrl_q    <= ctl_data;
      else if (ctrl_q[3]) ctrl_q[3] <= 1'b0;

      if (ctl_wr)      seen_q <= 1'b0;
      else if (accept) seen_q <= 1'b1;

      if (accept)          cnt_q <= (holdoff <= ONE) ? '0 : holdoff - ONE;
      else if (cnt_q != 0) cnt_q <= cnt_q - ONE;

      sync_q <= fire;
      init_q <= fire & ctrl_q[2];
    end
  end

  assign sync_pulse = sync_q;
  assign init_pulse = init_q;
  assign bypass     = ctrl_q[0];

  p_init_with_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |-> sync_pulse);

  p_init_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pulse && !$past(ctrl_q[2])) |-> !init_pulse);

  p_zero_holdoff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && holdoff == '0 && !ctrl_q[3]) |=> !sync_pulse);

  p_now_self_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[3] && !ctl_wr) |=> (sync_pulse && !ctrl_q[3]));

  p_repeat_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[1] && seen_q && ext && cnt_q > ONE) |=> cnt_q == $past(cnt_q) - ONE);

  p_bypass_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> bypass == $past(ctl_data[0]));

endmodule

// File: tb/agc_sync_sched_tb.sv
module agc_sync_sched_tb;
  localparam int CW = 4;

  logic clk = 0, rst_n = 0, ctl_wr = 0, pin_sync = 0, soft_sync = 0;
  logic [3:0] ctl_data = '0;
  logic [CW-1:0] holdoff = '0;
  logic sync_pulse, init_pulse, bypass;
  int runs = 0, fails = 0;

  always #2.5 clk = ~clk;

  agc_sync_sched #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .holdoff(holdoff), .pin_sync(pin_sync), .soft_sync(soft_sync),
    .sync_pulse(sync_pulse), .init_pulse(init_pulse), .bypass(bypass));

  // {holdoff[4], ctl[4], pin, soft, latency[5] (31 = none), init}
  localparam logic [15:0] VEC [8] = '{
    {4'd1,  4'h0, 1'b1, 1'b0, 5'd0,  1'b0},
    {4'd2,  4'h4, 1'b0, 1'b1, 5'd1,  1'b1},
    {4'd3,  4'h0, 1'b1, 1'b1, 5'd2,  1'b0},
    {4'd7,  4'h4, 1'b1, 1'b0, 5'd6,  1'b1},
    {4'd15, 4'h0, 1'b0, 1'b1, 5'd14, 1'b0},
    {4'd0,  4'h4, 1'b1, 1'b0, 5'd31, 1'b0},
    {4'd4,  4'h2, 1'b1, 1'b0, 5'd3,  1'b0},
    {4'd9,  4'h6, 1'b0, 1'b1, 5'd8,  1'b1}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [3:0] d);
    @(negedge clk); ctl_wr = 1; ctl_data = d;
    @(posedge clk);
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic run_ext(input logic p, input logic s, input int win,
                         output int first, output int n, output int ni);
    @(negedge clk); pin_sync = p; soft_sync = s;
    @(posedge clk);
    @(negedge clk); pin_sync = 0; soft_sync = 0;
    first = -1; n = 0; ni = 0;
    for (int i = 0; i < win; i++) begin
      if (i > 0) begin @(posedge clk); @(negedge clk); end
      if (sync_pulse) begin if (first < 0) first = i; n++; end
      if (init_pulse) ni++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    int first, n, ni;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!sync_pulse && !init_pulse && !bypass, "R1 reset outputs",
          {sync_pulse, init_pulse, bypass}, 0);
    rst_n = 1;
    repeat (20) @(negedge clk);
    check(!sync_pulse, "R1 idle after reset", sync_pulse, 0);

    for (int v = 0; v < 8; v++) begin
      logic [15:0] e;
      int exp_lat;
      e = VEC[v];
      holdoff = e[15:12];
      wr_ctl(e[11:8]);
      check(bypass == e[8], "R9 bypass level", bypass, e[8]);
      run_ext(e[7], e[6], 20, first, n, ni);
      exp_lat = (e[5:1] == 5'd31) ? -1 : int'(e[5:1]);
      check(first == exp_lat, "R2/R3/R10 latency", first, exp_lat);
      check(n == (exp_lat < 0 ? 0 : 1), "R2/R10 pulse count", n, exp_lat < 0 ? 0 : 1);
      check(ni == (e[0] ? n : 0), "R6 init pulses", ni, e[0] ? n : 0);
    end

    // R4 retrigger mid-count
    wr_ctl(4'h0); holdoff = 6;
    run_ext(1, 0, 3, first, n, ni);
    check(n == 0, "R4 no pulse before expiry", n, 0);
    run_ext(0, 1, 20, first, n, ni);
    check(first == 5 && n == 1, "R4 restart latency", first, 5);

    // R3 cancel with zero holdoff
    run_ext(1, 0, 3, first, n, ni);
    holdoff = 0;
    run_ext(1, 0, 20, first, n, ni);
    check(n == 0, "R3 zero holdoff cancels", n, 0);

    // R7 first only, R8 write re-arms
    holdoff = 2; wr_ctl(4'h2);
    run_ext(1, 0, 5, first, n, ni);
    check(first == 1 && n == 1, "R7 first sync honoured", first, 1);
    run_ext(0, 1, 10, first, n, ni);
    check(n == 0, "R7 repeat discarded", n, 0);
    wr_ctl(4'h2);
    run_ext(1, 0, 5, first, n, ni);
    check(first == 1 && n == 1, "R8 write re-arms", first, 1);

    // R5 immediate self-clearing, with R6 init
    wr_ctl(4'hC);
    check(!sync_pulse, "R5 no pulse at write edge", sync_pulse, 0);
    @(posedge clk); @(negedge clk);
    check(sync_pulse && init_pulse, "R5/R6 immediate pulse", {sync_pulse, init_pulse}, 3);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); @(negedge clk);
      if (sync_pulse) n++;
    end
    check(n == 0, "R5 self-clear", n, 0);

    wr_ctl(4'h1);
    check(bypass, "R9 bypass set", bypass, 1);
    @(negedge clk); rst_n = 0;
    @(posedge clk); @(negedge clk);
    check(!bypass && !sync_pulse, "R1 reset clears bypass", bypass, 0);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule